// File: doc/BRIEF.md
# Time-Multiplexed Servo Pulse Sequencer

This block drives a large set of hobby servos from a handful of pins. It has three pulse outputs, one per bank, and a three-bit select bus. External 3-to-8 demultiplexers, one per bank, send each pulse output to the servo picked by the select bus. Time is split into eight equal slots that together form one frame. In every slot the select bus carries the slot number, and each bank output produces one pulse whose width is the stored duty value of the channel in that bank and slot. With the default parameters, a 125 MHz clock and a prescaler of 125 give a 1 µs tick. A slot is then 2500 ticks (2.5 ms), and every one of the 24 servos gets one pulse per 20 ms frame.

A plain write port updates the duty table. Channel number `c` addresses bank `c >> 3` and slot `c & 7`. Every value written is clamped into the legal servo range. Channel numbers beyond the table are dropped. The duty values used in a slot are latched into compare registers when the slot starts, so a write can never change a pulse that is already being produced.

The sequencer is a small state machine with two states. `ST_ARM` is the state that reset forces. From it the unconditional *start* transition loads the compare values for slot 0, pulses `frame_start` and enters `ST_RUN`. `ST_RUN` stays in `ST_RUN`. On the last tick of each slot it takes the *roll* transition: the tick counter returns to zero, the slot index advances, and the compare values for the new slot are reloaded.

Top module: `servo_mux_pwm`

## Requirements
- R1: While reset is asserted, `sel`, `pulse` and `frame_start` are all zero. On the first clock edge after reset is released, the sequencer leaves `ST_ARM` and enters `ST_RUN` with slot 0. On that same edge `frame_start` rises and every bank pulse starts high.
- R2: The slot tick counter advances once every `TICK_DIV` clocks. A slot lasts `SLOT_TICKS` ticks, which is `TICK_DIV*SLOT_TICKS` clocks, and a frame lasts eight slots.
- R3: `sel` carries the slot index in binary: `sel[0]` is bit 0, `sel[1]` is bit 1 and `sel[2]` is bit 2. It is constant for the whole slot, advances by one at each rollover, and wraps from 7 to 0.
- R4: Bank output `pulse[b]` is high from the start of a slot while the tick count is below that slot's latched duty value for bank `b`. It is low for the rest of the slot.
- R5: A write to channel `c` sets the entry for bank `c >> 3` and slot `c & 7`. Channels 0–7 belong to bank 0, channels 8–15 to bank 1 and channels 16–23 to bank 2.
- R6: A written duty value below `DUTY_MIN` (default 899) is stored as `DUTY_MIN`. A value above `DUTY_MAX` (default 2099) is stored as `DUTY_MAX`. Values in between are stored unchanged.
- R7: A write to channel 24 or higher has no effect on any output.
- R8: After reset, every entry holds `(DUTY_MIN+DUTY_MAX)/2`, which is 1499 by default.
- R9: Compare values are reloaded only at a slot rollover, from the entries of the new slot. A write made in the middle of a slot leaves the pulse of that slot unchanged and takes effect the next time the slot comes round.
- R10: `frame_start` is high for exactly one clock, in the first clock of slot 0, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Duty write strobe |
| wr_ch | input | 5 | Channel number to write |
| wr_duty | input | 12 | Duty value in ticks, clamped before storage |
| sel | output | 3 | Binary slot index for the external demultiplexers |
| pulse | output | 3 | Pulse outputs, one per bank |
| frame_start | output | 1 | One-clock strobe when slot 0 begins |

## Verification
The hardest situation to reach from the ports is a write that lands in the middle of a slot on the very entry being emitted at that moment, while the old value must still shape the rest of that pulse. The bench builds the DUT with a short slot, a prescaler of 3 and a narrow clamp range. It keeps a cycle index aligned to `frame_start` and uses that index to time writes. One write hits the active slot's entries exactly halfway through the slot. All other writes are kept clear of rollover edges, so the expected compare values the bench latches at each slot start are unambiguous. Every cycle of every frame is then compared against the arithmetic model.

// File: rtl/servo_pkg.sv
package servo_pkg;

    typedef enum logic [0:0] {
        ST_ARM = 1'b0,
        ST_RUN = 1'b1
    } seq_state_t;

endpackage

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (!rst_n)             pcnt <= '0;
                else if (pcnt == PLAST) pcnt <= '0;
                else                    pcnt <= pcnt + 1'b1;
            end

            assign tick = (pcnt == PLAST);

            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/servo_duty_store.sv
module servo_duty_store #(
    parameter int N_BANKS  = 3,
    parameter int N_SLOTS  = 8,
    parameter int DUTY_W   = 12,
    parameter int DUTY_MIN = 899,
    parameter int DUTY_MAX = 2099,
    localparam int N_CH   = N_BANKS * N_SLOTS,
    localparam int CH_W   = $clog2(N_CH),
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [CH_W-1:0]                  wr_ch,
    input  logic [DUTY_W-1:0]                wr_duty,
    input  logic [SLOT_W-1:0]                rd_slot,
    output logic [N_BANKS-1:0][DUTY_W-1:0]   rd_duty
);

    localparam logic [DUTY_W-1:0] LO  = DUTY_W'(DUTY_MIN);
    localparam logic [DUTY_W-1:0] HI  = DUTY_W'(DUTY_MAX);
    localparam logic [DUTY_W-1:0] MID = DUTY_W'((DUTY_MIN + DUTY_MAX) / 2);

    logic [N_BANKS-1:0][N_SLOTS-1:0][DUTY_W-1:0] tab;
    logic [DUTY_W-1:0] clamped;

    always_comb begin
        if (wr_duty < LO)      clamped = LO;
        else if (wr_duty > HI) clamped = HI;
        else                   clamped = wr_duty;
    end

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
                localparam logic [CH_W-1:0] MY_CH = CH_W'(b * N_SLOTS + s);
                always_ff @(posedge clk) begin
                    if (!rst_n)                        tab[b][s] <= MID;
                    else if (wr_en && wr_ch == MY_CH)  tab[b][s] <= clamped;
                end

                // R6
                entry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (tab[b][s] >= LO) && (tab[b][s] <= HI));
            end
            assign rd_duty[b] = tab[b][rd_slot];
        end
    endgenerate

    // R7
    bad_ch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_ch} >= (CH_W + 1)'(N_CH))) |=> $stable(tab));

endmodule

// File: rtl/servo_slot_seq.sv
module servo_slot_seq
    import servo_pkg::*;
#(
    parameter int SLOT_TICKS = 2500,
    parameter int N_SLOTS    = 8,
    parameter int N_BANKS    = 3,
    parameter int DUTY_W     = 12,
    localparam int CNT_W  = $clog2(SLOT_TICKS),
    localparam int SLOT_W = $clog2(N_SLOTS),
    localparam int CMP_W  = (CNT_W > DUTY_W) ? CNT_W : DUTY_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic [N_BANKS-1:0][DUTY_W-1:0] rd_duty,
    output logic [SLOT_W-1:0]              rd_slot,
    output logic [SLOT_W-1:0]              sel,
    output logic [N_BANKS-1:0]             pulse,
    output logic                           frame_start
);

    localparam logic [CNT_W-1:0]  LAST     = CNT_W'(SLOT_TICKS - 1);
    localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(N_SLOTS - 1);

    seq_state_t state, state_nxt;
    logic [CNT_W-1:0]              cnt;
    logic [SLOT_W-1:0]             slot, slot_nxt;
    logic [N_BANKS-1:0][DUTY_W-1:0] cmp;
    logic                          roll;

    assign slot_nxt = (slot == SLOT_TOP) ? '0 : slot + 1'b1;
    assign roll     = (state == ST_RUN) && tick && (cnt == LAST);
    assign rd_slot  = (state == ST_ARM) ? '0 : slot_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARM;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_ARM:  state_nxt = ST_RUN;
            ST_RUN:  state_nxt = ST_RUN;
            default: state_nxt = ST_ARM;
        endcase
    end

    // tick counter, slot index and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            slot        <= '0;
            cmp         <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            unique case (state)
                ST_ARM: begin
                    cnt         <= '0;
                    slot        <= '0;
                    cmp         <= rd_duty;
                    frame_start <= 1'b1;
                end
                ST_RUN: begin
                    if (roll) begin
                        cnt         <= '0;
                        slot        <= slot_nxt;
                        cmp         <= rd_duty;
                        frame_start <= (slot_nxt == '0);
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sel = slot;
        for (int b = 0; b < N_BANKS; b++) begin
            pulse[b] = (state == ST_RUN) && (CMP_W'(cnt) < CMP_W'(cmp[b]));
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && !roll) |=> $stable(sel));

    // R3
    sel_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && (slot == SLOT_TOP)) |=> (sel == '0));

    // R9
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && !roll) |=> $stable(cmp));

    // R10
    frame_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ((cnt == '0) && (slot == '0)));

    // R10
    frame_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

// File: rtl/servo_mux_pwm.sv
module servo_mux_pwm #(
    parameter int TICK_DIV   = 125,
    parameter int SLOT_TICKS = 2500,
    parameter int N_SLOTS    = 8,
    parameter int N_BANKS    = 3,
    parameter int DUTY_W     = 12,
    parameter int DUTY_MIN   = 899,
    parameter int DUTY_MAX   = 2099
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2(N_BANKS*N_SLOTS)-1:0]     wr_ch,
    input  logic [DUTY_W-1:0]                      wr_duty,
    output logic [$clog2(N_SLOTS)-1:0]             sel,
    output logic [N_BANKS-1:0]                     pulse,
    output logic                                   frame_start
);

    localparam int SLOT_W = $clog2(N_SLOTS);

    logic                           tick;
    logic [SLOT_W-1:0]              rd_slot;
    logic [N_BANKS-1:0][DUTY_W-1:0] rd_duty;

    servo_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    servo_duty_store #(
        .N_BANKS  (N_BANKS),
        .N_SLOTS  (N_SLOTS),
        .DUTY_W   (DUTY_W),
        .DUTY_MIN (DUTY_MIN),
        .DUTY_MAX (DUTY_MAX)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_duty (wr_duty),
        .rd_slot (rd_slot),
        .rd_duty (rd_duty)
    );

    servo_slot_seq #(
        .SLOT_TICKS (SLOT_TICKS),
        .N_SLOTS    (N_SLOTS),
        .N_BANKS    (N_BANKS),
        .DUTY_W     (DUTY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rd_duty     (rd_duty),
        .rd_slot     (rd_slot),
        .sel         (sel),
        .pulse       (pulse),
        .frame_start (frame_start)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> (pulse == '0) && (sel == '0) && !frame_start);

endmodule

// File: tb/tb_servo_mux_pwm.sv
module tb_servo_mux_pwm;

    localparam int DIV  = 3;
    localparam int SLT  = 40;
    localparam int DMIN = 9;
    localparam int DMAX = 29;
    localparam int SC   = DIV * SLT;
    localparam int FC   = SC * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_ch = '0;
    logic [11:0] wr_duty = '0;
    logic [2:0]  sel;
    logic [2:0]  pulse;
    logic        frame_start;

    int    n_chk = 0;
    int    n_err = 0;
    int    exp_tab [3][8];
    int    cap [3];
    bit    run_chk = 1'b0;
    bit    track = 1'b0;
    bit    done = 1'b0;
    int    fs_seen = 0;
    int    k = 0;
    string cur_tag = "R8";

    always #4 clk = ~clk;

    servo_mux_pwm #(
        .TICK_DIV   (DIV),
        .SLOT_TICKS (SLT),
        .DUTY_MIN   (DMIN),
        .DUTY_MAX   (DMAX)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_ch       (wr_ch),
        .wr_duty     (wr_duty),
        .sel         (sel),
        .pulse       (pulse),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int clampf(input int d);
        if (d < DMIN) return DMIN;
        if (d > DMAX) return DMAX;
        return d;
    endfunction

    // per-cycle arithmetic model, aligned to the second frame_start
    always @(negedge clk) begin
        if (run_chk) begin
            if (!track && frame_start) begin
                fs_seen++;
                if (fs_seen == 2) begin
                    track = 1'b1;
                    k = 0;
                end
            end
            if (track) begin
                int kk, sl, tc;
                kk = k % FC;
                sl = kk / SC;
                tc = (kk % SC) / DIV;
                if (kk % SC == 0) begin
                    for (int b = 0; b < 3; b++) cap[b] = exp_tab[b][sl];
                end
                chk(sel == 3'(sl), "R2 R3 sel", int'(sel), sl);
                chk(frame_start == (kk == 0), "R10 frame_start", int'(frame_start), int'(kk == 0));
                for (int b = 0; b < 3; b++) begin
                    chk(pulse[b] == (tc < cap[b]), {cur_tag, " pulse"}, int'(pulse[b]), int'(tc < cap[b]));
                end
                k++;
            end
        end
    end

    task automatic wr_entry(input int ch, input int d);
        do begin
            @(posedge clk); #1;
        end while (!(track && (k % SC) >= 2 && (k % SC) <= SC - 3));
        wr_en   = 1'b1;
        wr_ch   = 5'(ch);
        wr_duty = 12'(d);
        if (ch < 24) exp_tab[ch / 8][ch % 8] = clampf(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_frames(input int n);
        repeat (n * FC) @(posedge clk);
    endtask

    initial begin
        for (int b = 0; b < 3; b++)
            for (int s = 0; s < 8; s++) exp_tab[b][s] = (DMIN + DMAX) / 2;

        // R1: quiet outputs while reset is held
        repeat (4) @(negedge clk);
        chk(pulse == 3'b000, "R1 reset pulse", int'(pulse), 0);
        chk(sel == 3'b000, "R1 reset sel", int'(sel), 0);
        chk(frame_start == 1'b0, "R1 reset frame_start", int'(frame_start), 0);
        rst_n = 1'b1;
        run_chk = 1'b1;
        @(negedge clk);
        // R1: first edge after release enters run with slot 0
        chk(frame_start == 1'b1, "R1 start frame_start", int'(frame_start), 1);
        chk(sel == 3'b000, "R1 start sel", int'(sel), 0);
        chk(pulse == 3'b111, "R1 start pulse", int'(pulse), 7);

        wait (track);
        // R8: a full frame on reset defaults
        cur_tag = "R8";
        run_frames(1);

        // R4 R5 R6: distinct values per channel, several out of range
        cur_tag = "R4 R5 R6";
        for (int ch = 0; ch < 24; ch++) wr_entry(ch, (ch * 5 + 3) % 45);
        wr_entry(2, 4095);
        wr_entry(13, 0);
        run_frames(2);

        // R7: writes beyond the table must change nothing
        cur_tag = "R7";
        for (int ch = 24; ch < 32; ch++) begin
            wr_entry(ch, 0);
            wr_entry(ch, 4095);
        end
        run_frames(1);

        // R9: write the active slot's entries halfway through the slot
        cur_tag = "R9";
        do begin
            @(posedge clk); #1;
        end while ((k % SC) != SC / 2);
        begin
            int s;
            s = (k % FC) / SC;
            wr_en   = 1'b1;
            wr_ch   = 5'(s);
            wr_duty = 12'((exp_tab[0][s] == DMAX) ? DMIN : DMAX);
            exp_tab[0][s] = (exp_tab[0][s] == DMAX) ? DMIN : DMAX;
            @(posedge clk); #1;
            wr_ch   = 5'(16 + s);
            wr_duty = 12'((exp_tab[2][s] == DMIN) ? DMAX : DMIN);
            exp_tab[2][s] = (exp_tab[2][s] == DMIN) ? DMAX : DMIN;
            @(posedge clk); #1;
            wr_en = 1'b0;
        end
        run_frames(2);

        // R6: all entries at each clamp limit
        cur_tag = "R6";
        for (int ch = 0; ch < 24; ch++) wr_entry(ch, 1);
        run_frames(1);
        for (int ch = 0; ch < 24; ch++) wr_entry(ch, 3000);
        run_frames(1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule